// File: doc/BRIEF.md
# Serial Flash Programming Sequencer

This block is the master side of an in-system programming link to a small 8-bit microcontroller whose 8 KB flash is reached over four wires: a serial clock, a data line out, a data line in and a target reset. A host hands it one command at a time on a valid/ready port. The commands are: enter programming mode, erase the whole flash, read a signature byte, read one flash byte and write one flash byte. For each one the sequencer builds a four-byte frame, clocks it out in SPI mode 0 and keeps the reply bytes. It then holds off any further traffic for the settle or busy time that the command needs, and returns one response carrying a data byte and an error flag.

Entering programming mode raises the target reset line. In this design a high level holds the part in programming mode. The sequencer keeps the clock low for a stabilisation time and then sends the enable frame. The enable succeeds only if the part echoes the frame's second byte back as the third reply byte. If the echo is missing, the sequencer waits out the stabilisation time again and repeats the enable frame, up to a fixed number of attempts. If every attempt fails, it reports a synchronisation error and releases the target.

All timing is counted in system clock cycles. The serial clock divider, the stabilisation time, the erase wait, the write wait and the attempt limit are all parameters.

Top module: `isp_prog_seq`

## Requirements
- R1: After reset, `isp_rst` and `isp_sck` are low, `busy` is low and `cmd_ready` is high.
- R2: Every byte is sent MSB first in SPI mode 0. SCK idles low and each byte has eight SCK pulses, each half-period lasting `CLK_DIV` cycles. MOSI changes only while SCK is low, and MISO is sampled at each SCK rising edge.
- R3: An enter command (`cmd_op` = 0) drives `isp_rst` high, where high means hold the target in programming mode. SCK then stays low for at least `STAB_CYC` cycles before the enable frame 0xAC 0x53 0x00 0x00 starts.
- R4: Entry succeeds when the third byte received in the enable frame equals 0x53. The response then has `rsp_err` = 0 and `rsp_data` = 0x53.
- R5: After a failed echo, the enable frame is repeated after another stabilisation wait. After `MAX_TRIES` failed frames the response has `rsp_err` = 1 and `isp_rst` returns low.
- R6: An erase (`cmd_op` = 1) sends 0xAC, then a byte whose top three bits are 100, then two zero bytes. The response comes no sooner than `ERASE_CYC` cycles after the frame's last SCK falling edge.
- R7: A flash read (`cmd_op` = 3) sends 0x20, then {3'b000, addr[12:8]}, then addr[7:0], then 0x00. `rsp_data` is the fourth byte received.
- R8: A flash write (`cmd_op` = 4) sends 0x40, then the same two address bytes, then `cmd_data`. The response comes no sooner than `WRITE_CYC` cycles after the frame's last SCK falling edge.
- R9: A signature read (`cmd_op` = 2) sends 0x28, then 0x00, then {6'b0, addr[1:0]}, then 0x00. `rsp_data` is the fourth byte received.
- R10: A command is accepted only while `cmd_ready` is high. `busy` is high from acceptance through the frame and any wait. Each accepted command gives exactly one single-cycle `rsp_valid` pulse, in the cycle `busy` falls. SCK never pulses while `busy` is low.
- R11: A framed command issued before a successful entry, and any undefined `cmd_op` value (5 to 7), is answered with `rsp_err` = 1 and produces no SCK pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Sequencer idle and accepting a command |
| cmd_op | input | 3 | 0 enter, 1 erase, 2 signature, 3 read, 4 write |
| cmd_addr | input | 13 | Flash address, or signature index in bits 1..0 |
| cmd_data | input | 8 | Byte to program for a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Echo byte for an enter, otherwise the fourth reply byte |
| rsp_err | output | 1 | Synchronisation failure or command refused |
| busy | output | 1 | A command is in progress |
| isp_sck | output | 1 | Serial clock to the target |
| isp_mosi | output | 1 | Serial data to the target |
| isp_miso | input | 1 | Serial data from the target |
| isp_rst | output | 1 | Target reset, high holds programming mode |

## Verification
The bench's target model withholds the echo for a set number of enable frames. This catches an off-by-one in the attempt limit, which would show up as a wrong count of enable frames or as a stray success after the limit. It measures the time from the reset rising edge to the first SCK rising edge, and from the last SCK falling edge to the response. A design that shortened the stabilisation time or the erase or write busy time would report too early. Random reads and writes across the 13-bit address range, with the high address bits in use, expose swapped or truncated address bytes through the frame contents and the data read back. Commands sent before entry and undefined opcodes must return an error with no clock activity.

// File: rtl/isp_pkg.sv
// Package isp_pkg
// Shared command codes, frame opcodes and the frame builder for the serial
// programming sequencer. Assumes frames of four bytes, MSB first.
package isp_pkg;

    localparam int FRAME_BYTES = 4;

    // Host command codes on cmd_op
    localparam logic [2:0] OP_ENTER = 3'd0;
    localparam logic [2:0] OP_ERASE = 3'd1;
    localparam logic [2:0] OP_SIG   = 3'd2;
    localparam logic [2:0] OP_READ  = 3'd3;
    localparam logic [2:0] OP_WRITE = 3'd4;

    // Bytes placed on the wire
    localparam logic [7:0] WIRE_PREFIX = 8'hAC;
    localparam logic [7:0] ENABLE_KEY  = 8'h53;
    localparam logic [7:0] ERASE_SEL   = 8'h80;
    localparam logic [7:0] WIRE_RD     = 8'h20;
    localparam logic [7:0] WIRE_WR     = 8'h40;
    localparam logic [7:0] WIRE_SIG    = 8'h28;

    // True for commands that need programming mode and send a frame
    function automatic logic is_framed(input logic [2:0] op);
        return (op == OP_ERASE) || (op == OP_SIG) || (op == OP_READ) || (op == OP_WRITE);
    endfunction

    // Build the four-byte frame for a command, first byte in bits 31..24
    function automatic logic [31:0] build_frame(input logic [2:0] op,
                                                input logic [12:0] addr,
                                                input logic [7:0] data);
        logic [31:0] f;
        case (op)
            OP_ENTER: f = {WIRE_PREFIX, ENABLE_KEY, 16'h0000};
            OP_ERASE: f = {WIRE_PREFIX, ERASE_SEL, 16'h0000};
            OP_SIG:   f = {WIRE_SIG, 8'h00, 6'b000000, addr[1:0], 8'h00};
            OP_READ:  f = {WIRE_RD, 3'b000, addr[12:8], addr[7:0], 8'h00};
            OP_WRITE: f = {WIRE_WR, 3'b000, addr[12:8], addr[7:0], data};
            default:  f = 32'h0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/isp_byte_shift.sv
// Module isp_byte_shift
// Moves one byte over a mode-0 link: SCK idles low, MOSI launches on the
// falling edge (first bit on start), MISO is taken on the rising edge.
// Each SCK half-period lasts DIV system cycles. Assumes start only when idle.
module isp_byte_shift #(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done,
    output logic       busy
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          active;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;

    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;
    assign busy    = active;

    // Half-period divider, SCK toggling, shift out on fall and in on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    tx_sr   <= tx_byte;
                    sck     <= 1'b0;
                    bit_idx <= '0;
                    div_cnt <= '0;
                end
            end else if (div_cnt != DW'(DIV - 1)) begin
                div_cnt <= div_cnt + 1'b1;
            end else begin
                div_cnt <= '0;
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sr <= {rx_sr[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        tx_sr   <= {tx_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R2: clock rests low whenever no byte is in flight
    a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sck);
    // R2: data out holds while the clock is high
    a_r2_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/isp_wait_timer.sv
// Module isp_wait_timer
// One-shot down-counter. A load with count N gives one expired pulse N
// cycles later (one cycle later for N = 0). Assumes no load while running.
module isp_wait_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] count,
    output logic         expired,
    output logic         running
);
    logic [W-1:0] remain;

    // Count down from the loaded value and flag the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                if (count == '0) begin
                    expired <= 1'b1;
                end else begin
                    remain  <= count - 1'b1;
                    running <= 1'b1;
                end
            end else if (running) begin
                if (remain == '0) begin
                    running <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    // R6: a fresh load never lands on a running count
    a_r6_no_reload_running: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running);
    // R8: the end pulse stops the count
    a_r8_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> !running);

endmodule

// File: rtl/isp_frame_engine.sv
// Module isp_frame_engine
// Sends a four-byte frame through the byte shifter, first byte from bits
// 31..24, and gathers the four reply bytes in the same order.
// Assumes start only while not busy.
module isp_frame_engine
    import isp_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] frame,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic [31:0] rx_frame,
    output logic        done,
    output logic        busy
);
    localparam int IW = $clog2(FRAME_BYTES);

    logic          active;
    logic [IW-1:0] idx;
    logic [31:0]   frame_q;
    logic          sh_start;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;
    logic          sh_done;
    logic          sh_busy;

    assign busy = active;

    // Pick the outgoing byte for the current position
    always_comb begin
        case (idx)
            2'd0:    sh_tx = frame_q[31:24];
            2'd1:    sh_tx = frame_q[23:16];
            2'd2:    sh_tx = frame_q[15:8];
            default: sh_tx = frame_q[7:0];
        endcase
    end

    // Step through the byte positions and store each reply byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            frame_q  <= '0;
            sh_start <= 1'b0;
            rx_frame <= '0;
            done     <= 1'b0;
        end else begin
            sh_start <= 1'b0;
            done     <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    idx      <= '0;
                    frame_q  <= frame;
                    sh_start <= 1'b1;
                end
            end else if (sh_done) begin
                case (idx)
                    2'd0:    rx_frame[31:24] <= sh_rx;
                    2'd1:    rx_frame[23:16] <= sh_rx;
                    2'd2:    rx_frame[15:8]  <= sh_rx;
                    default: rx_frame[7:0]   <= sh_rx;
                endcase
                if (idx == IW'(FRAME_BYTES - 1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx      <= idx + 1'b1;
                    sh_start <= 1'b1;
                end
            end
        end
    end

    isp_byte_shift #(.DIV(DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .rx_byte (sh_rx),
        .done    (sh_done),
        .busy    (sh_busy)
    );

    // R2: a byte is only launched into an idle shifter
    a_r2_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_busy);
    // R2: completed bytes belong to an open frame
    a_r2_done_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |-> active);

endmodule

// File: rtl/isp_prog_seq.sv
// Module isp_prog_seq
// Top of the programming sequencer. Takes host commands, drives the target
// reset (high = programming mode), runs the entry handshake with retries,
// sends command frames and applies the post-command waits before replying.
// Assumes the host holds cmd_* stable while cmd_valid is high.
module isp_prog_seq
    import isp_pkg::*;
#(
    parameter int CLK_DIV   = 40,
    parameter int STAB_CYC  = 5000,
    parameter int ERASE_CYC = 25000000,
    parameter int WRITE_CYC = 200000,
    parameter int MAX_TRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_op,
    input  logic [12:0] cmd_addr,
    input  logic [7:0]  cmd_data,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    output logic        rsp_err,
    output logic        busy,
    output logic        isp_sck,
    output logic        isp_mosi,
    input  logic        isp_miso,
    output logic        isp_rst
);
    localparam int LONG_WAIT = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int WAIT_MAX  = (LONG_WAIT > STAB_CYC) ? LONG_WAIT : STAB_CYC;
    localparam int TW        = $clog2(WAIT_MAX + 1);
    localparam int TRY_W     = $clog2(MAX_TRIES + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_SETTLE, S_ENABLE, S_FRAME, S_HOLD, S_REPLY
    } seq_state_e;

    seq_state_e      state;
    logic            entered;
    logic [TRY_W-1:0] tries;
    logic            rst_q;
    logic            fe_start_q;
    logic [31:0]     fe_frame_q;
    logic            tmr_load_q;
    logic [TW-1:0]   tmr_count_q;
    logic [TW-1:0]   post_q;
    logic            rsp_valid_q;
    logic [7:0]      rsp_data_q;
    logic            rsp_err_q;
    logic [31:0]     fe_rx;
    logic            fe_done;
    logic            fe_busy;
    logic            tmr_expired;
    logic            tmr_running;

    assign cmd_ready = (state == S_IDLE);
    assign busy      = (state != S_IDLE);
    assign isp_rst   = rst_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign rsp_err   = rsp_err_q;

    // Command sequencing: entry handshake, framed commands, waits, reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            entered     <= 1'b0;
            tries       <= '0;
            rst_q       <= 1'b0;
            fe_start_q  <= 1'b0;
            fe_frame_q  <= '0;
            tmr_load_q  <= 1'b0;
            tmr_count_q <= '0;
            post_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            rsp_err_q   <= 1'b0;
        end else begin
            fe_start_q  <= 1'b0;
            tmr_load_q  <= 1'b0;
            rsp_valid_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_op == OP_ENTER) begin
                            rst_q       <= 1'b1;
                            entered     <= 1'b0;
                            tries       <= '0;
                            tmr_load_q  <= 1'b1;
                            tmr_count_q <= TW'(STAB_CYC);
                            state       <= S_SETTLE;
                        end else if (is_framed(cmd_op) && entered) begin
                            fe_start_q <= 1'b1;
                            fe_frame_q <= build_frame(cmd_op, cmd_addr, cmd_data);
                            if (cmd_op == OP_ERASE)
                                post_q <= TW'(ERASE_CYC);
                            else if (cmd_op == OP_WRITE)
                                post_q <= TW'(WRITE_CYC);
                            else
                                post_q <= '0;
                            state <= S_FRAME;
                        end else begin
                            rsp_err_q  <= 1'b1;
                            rsp_data_q <= 8'h00;
                            state      <= S_REPLY;
                        end
                    end
                end
                S_SETTLE: begin
                    if (tmr_expired) begin
                        fe_start_q <= 1'b1;
                        fe_frame_q <= build_frame(OP_ENTER, 13'd0, 8'd0);
                        state      <= S_ENABLE;
                    end
                end
                S_ENABLE: begin
                    if (fe_done) begin
                        rsp_data_q <= fe_rx[15:8];
                        if (fe_rx[15:8] == ENABLE_KEY) begin
                            entered   <= 1'b1;
                            rsp_err_q <= 1'b0;
                            state     <= S_REPLY;
                        end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
                            tries     <= tries + 1'b1;
                            rst_q     <= 1'b0;
                            rsp_err_q <= 1'b1;
                            state     <= S_REPLY;
                        end else begin
                            tries       <= tries + 1'b1;
                            tmr_load_q  <= 1'b1;
                            tmr_count_q <= TW'(STAB_CYC);
                            state       <= S_SETTLE;
                        end
                    end
                end
                S_FRAME: begin
                    if (fe_done) begin
                        rsp_data_q  <= fe_rx[7:0];
                        rsp_err_q   <= 1'b0;
                        tmr_load_q  <= 1'b1;
                        tmr_count_q <= post_q;
                        state       <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (tmr_expired) state <= S_REPLY;
                end
                S_REPLY: begin
                    rsp_valid_q <= 1'b1;
                    state       <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    isp_frame_engine #(.DIV(CLK_DIV)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fe_start_q),
        .frame    (fe_frame_q),
        .miso     (isp_miso),
        .sck      (isp_sck),
        .mosi     (isp_mosi),
        .rx_frame (fe_rx),
        .done     (fe_done),
        .busy     (fe_busy)
    );

    isp_wait_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load_q),
        .count   (tmr_count_q),
        .expired (tmr_expired),
        .running (tmr_running)
    );

    // R3: no clocking while the target is released
    a_r3_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !isp_rst |-> !isp_sck);
    // R5: attempt count stays within its limit
    a_r5_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(MAX_TRIES));
    // R6: clock stays low during a post-command wait
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> !isp_sck);
    // R10: accepted commands raise busy next cycle
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);
    // R10: frames and timers only run under busy
    a_r10_frame_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_busy || tmr_running) |-> busy);
    // R10: response strobe lasts one cycle
    a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_isp_prog_seq.sv
// Bench for isp_prog_seq: behavioural target with echo, sparse flash and
// signature; fixed-seed random reads and writes plus directed corners.
module tb_isp_prog_seq;

    localparam int DIV   = 2;
    localparam int STAB  = 20;
    localparam int ERASE = 300;
    localparam int WRT   = 40;
    localparam int TRIES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [12:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_err;
    logic        busy;
    logic        isp_sck;
    logic        isp_mosi;
    logic        isp_miso;
    logic        isp_rst;

    always #10 clk = ~clk;

    isp_prog_seq #(
        .CLK_DIV(DIV), .STAB_CYC(STAB), .ERASE_CYC(ERASE),
        .WRITE_CYC(WRT), .MAX_TRIES(TRIES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .busy(busy), .isp_sck(isp_sck), .isp_mosi(isp_mosi),
        .isp_miso(isp_miso), .isp_rst(isp_rst)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    logic [7:0] tmem [int];
    logic [7:0] rxb [4];
    logic [7:0] rxsr = '0;
    logic [7:0] txsr = '0;
    logic       tgt_miso = 1'b0;
    int         bitc = 0;
    int         bidx = 0;
    int         frames = 0;
    int         en_frames = 0;
    int         fail_left = 0;
    logic [31:0] last_frame = '0;

    assign isp_miso = tgt_miso;

    function automatic logic [7:0] tgt_reply(input int i);
        logic [7:0] r;
        r = 8'h00;
        if (i == 2 && rxb[0] == 8'hAC && rxb[1] == 8'h53) begin
            if (fail_left > 0) begin
                fail_left--;
                r = 8'hFF;
            end else r = rxb[1];
        end else if (i == 3 && rxb[0] == 8'h20) begin
            r = tmem.exists(int'({rxb[1][4:0], rxb[2]})) ? tmem[int'({rxb[1][4:0], rxb[2]})] : 8'hFF;
        end else if (i == 3 && rxb[0] == 8'h28) begin
            case (rxb[2][1:0])
                2'd0: r = 8'h1E;
                2'd1: r = 8'h52;
                2'd2: r = 8'h06;
                default: r = 8'hFF;
            endcase
        end
        return r;
    endfunction

    always @(posedge isp_sck or negedge isp_sck) begin
        if (isp_sck) begin
            rxsr = {rxsr[6:0], isp_mosi};
            bitc++;
            if (bitc == 8) begin
                rxb[bidx] = rxsr;
                if (bidx == 3) begin
                    frames++;
                    last_frame = {rxb[0], rxb[1], rxb[2], rxb[3]};
                    if (rxb[0] == 8'hAC && rxb[1] == 8'h53) en_frames++;
                    if (rxb[0] == 8'hAC && rxb[1][7:5] == 3'b100) tmem.delete();
                    if (rxb[0] == 8'h40) tmem[int'({rxb[1][4:0], rxb[2]})] = rxb[3];
                    bidx = 0;
                end else bidx++;
            end
        end else begin
            if (bitc == 8) begin
                bitc = 0;
                txsr = tgt_reply(bidx);
            end else begin
                txsr = {txsr[6:0], 1'b0};
            end
            tgt_miso = txsr[7];
        end
    end

    // ---------------- monitor ----------------
    int  cyc = 0;
    int  last_fall = 0;
    int  rst_rise = 0;
    int  stab_gap = -1;
    bit  await_first = 1'b0;
    int  sck_rises = 0;
    int  idle_clk_err = 0;
    int  mosi_err = 0;
    int  rsp_dup_err = 0;
    int  rsp_n = 0;
    int  rsp_gap = 0;
    logic [7:0] rsp_d = '0;
    logic rsp_e = 1'b0;
    logic p_sck = 1'b0, p_rst = 1'b0, p_mosi = 1'b0, p_rv = 1'b0;

    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (rst_n) begin
            if (p_sck && !isp_sck) last_fall = cyc;
            if (!p_sck && isp_sck) begin
                sck_rises++;
                if (!busy) idle_clk_err++;
                if (await_first) begin
                    stab_gap = cyc - rst_rise;
                    await_first = 1'b0;
                end
            end
            if (!p_rst && isp_rst) begin
                rst_rise = cyc;
                await_first = 1'b1;
            end
            if (p_sck && isp_sck && (p_mosi != isp_mosi)) mosi_err++;
            if (rsp_valid) begin
                if (p_rv) rsp_dup_err++;
                if (busy) rsp_dup_err++;
                rsp_n++;
                rsp_d = rsp_data;
                rsp_e = rsp_err;
                rsp_gap = cyc - last_fall;
            end
        end
        p_sck = isp_sck; p_rst = isp_rst; p_mosi = isp_mosi; p_rv = rsp_valid;
    end

    // ---------------- host driver ----------------
    task automatic send(input logic [2:0] op, input logic [12:0] a, input logic [7:0] d);
        int n0;
        n0 = rsp_n;
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (rsp_n == n0) @(negedge clk);
        @(negedge clk);
    endtask

    logic [7:0] ref_mem [int];
    logic [12:0] waddr [40];

    function automatic logic [7:0] ref_read(input logic [12:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'hFF;
    endfunction

    function automatic logic [7:0] sig_exp(input logic [1:0] i);
        return (i == 2'd0) ? 8'h1E : (i == 2'd1) ? 8'h52 : (i == 2'd2) ? 8'h06 : 8'hFF;
    endfunction

    initial begin
        int r0, e0;
        void'($urandom(32'h1A77));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(isp_rst == 1'b0, "R1 isp_rst", {31'b0, isp_rst}, 32'h0);
        chk(isp_sck == 1'b0, "R1 isp_sck", {31'b0, isp_sck}, 32'h0);
        chk(busy == 1'b0 && cmd_ready == 1'b1, "R1 busy/ready", {30'b0, busy, cmd_ready}, 32'h1);

        // R11 framed command before entry, and undefined opcode
        r0 = sck_rises;
        send(3'd3, 13'h0123, 8'h00);
        chk(rsp_e == 1'b1, "R11 read before entry err", {31'b0, rsp_e}, 32'h1);
        send(3'd6, 13'h0000, 8'h00);
        chk(rsp_e == 1'b1, "R11 undefined op err", {31'b0, rsp_e}, 32'h1);
        chk(sck_rises == r0, "R11 no sck", sck_rises, r0);

        // R3 R4 R5 entry with three withheld echoes
        fail_left = 3;
        e0 = en_frames;
        send(3'd0, 13'h0, 8'h0);
        chk(rsp_e == 1'b0 && rsp_d == 8'h53, "R4 entry ok", {23'b0, rsp_e, rsp_d}, 32'h53);
        chk(en_frames - e0 == 4, "R5 retry count", en_frames - e0, 4);
        chk(last_frame == 32'hAC530000, "R3 enable frame", last_frame, 32'hAC530000);
        chk(isp_rst == 1'b1, "R3 reset high", {31'b0, isp_rst}, 32'h1);
        chk(stab_gap >= STAB && stab_gap <= STAB + DIV + 8, "R3 stabilisation", stab_gap, STAB);

        // R9 signature bytes
        for (int i = 0; i < 4; i++) begin
            send(3'd2, 13'(i), 8'h00);
            chk(rsp_d == sig_exp(2'(i)) && !rsp_e, "R9 signature data", {24'b0, rsp_d}, {24'b0, sig_exp(2'(i))});
            chk(last_frame == {8'h28, 8'h00, 6'b0, 2'(i), 8'h00}, "R9 signature frame", last_frame, {8'h28, 8'h00, 6'b0, 2'(i), 8'h00});
        end

        // R6 erase frame and busy wait
        send(3'd1, 13'h0, 8'h0);
        chk(last_frame[31:24] == 8'hAC && last_frame[23:21] == 3'b100 && last_frame[15:0] == 16'h0, "R6 erase frame", last_frame, 32'hAC800000);
        chk(rsp_gap >= ERASE && rsp_gap <= ERASE + 8, "R6 erase wait", rsp_gap, ERASE);
        ref_mem.delete();

        // R8 R7 random writes then read back
        for (int i = 0; i < 40; i++) begin
            logic [12:0] a;
            logic [7:0] d;
            a = (i == 0) ? 13'h1FFF : (i == 1) ? 13'h0000 : 13'($urandom);
            d = 8'($urandom);
            waddr[i] = a;
            send(3'd4, a, d);
            ref_mem[int'(a)] = d;
            chk(last_frame == {8'h40, 3'b000, a[12:8], a[7:0], d}, "R8 write frame", last_frame, {8'h40, 3'b000, a[12:8], a[7:0], d});
            chk(rsp_gap >= WRT && rsp_gap <= WRT + 8, "R8 write wait", rsp_gap, WRT);
        end
        for (int i = 0; i < 40; i++) begin
            send(3'd3, waddr[i], 8'h00);
            chk(rsp_d == ref_read(waddr[i]), "R7 read data", {24'b0, rsp_d}, {24'b0, ref_read(waddr[i])});
            chk(last_frame == {8'h20, 3'b000, waddr[i][12:8], waddr[i][7:0], 8'h00}, "R7 read frame", last_frame, {8'h20, 3'b000, waddr[i][12:8], waddr[i][7:0], 8'h00});
        end
        for (int i = 0; i < 10; i++) begin
            logic [12:0] a;
            a = 13'($urandom);
            send(3'd3, a, 8'h00);
            chk(rsp_d == ref_read(a), "R7 random read", {24'b0, rsp_d}, {24'b0, ref_read(a)});
        end

        // R6 erase clears, then unwritten read gives 0xFF
        send(3'd1, 13'h0, 8'h0);
        ref_mem.delete();
        send(3'd3, waddr[2], 8'h00);
        chk(rsp_d == 8'hFF, "R6 read after erase", {24'b0, rsp_d}, 32'hFF);

        // R5 entry that never syncs
        fail_left = 1000;
        e0 = en_frames;
        send(3'd0, 13'h0, 8'h0);
        chk(rsp_e == 1'b1, "R5 sync error", {31'b0, rsp_e}, 32'h1);
        chk(en_frames - e0 == TRIES, "R5 attempt limit", en_frames - e0, TRIES);
        chk(isp_rst == 1'b0, "R5 released", {31'b0, isp_rst}, 32'h0);
        r0 = sck_rises;
        send(3'd4, 13'h0010, 8'h5A);
        chk(rsp_e == 1'b1 && sck_rises == r0, "R11 write after failed entry", {31'b0, rsp_e}, 32'h1);
        fail_left = 0;

        // R2 and R10 global observations
        chk(mosi_err == 0, "R2 mosi stable while sck high", mosi_err, 0);
        chk(idle_clk_err == 0, "R10 no sck while idle", idle_clk_err, 0);
        chk(rsp_dup_err == 0, "R10 single rsp pulse with busy low", rsp_dup_err, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule